// File: doc/BRIEF.md
# Symmetric Pulse-Rejecting Input Filter

This block cleans the seven logic inputs of a three-phase gate-drive controller: three active-low high-side switch commands, three active-low low-side switch commands and one active-high enable. Each input has its own small counter. A raw level that differs from the current filtered level must be held for `QUAL_CYCLES` consecutive clock cycles before the filtered output adopts it. Any return to the old level before that point restarts the qualification.

Both edges of a pulse see the same delay, so an accepted pulse keeps its exact width in clock cycles. Narrow pulses are dropped whether they go high on a low line or low on a high line. With a 100 MHz clock, the default of 25 cycles gives a 250 ns qualification time. The raw inputs are assumed to be synchronous to `clk` already. The asynchronous active-low reset is released through a two-stage synchroniser.

Top module: `gate_in_filter`

## Requirements
- R1: While reset is asserted, and after it until a new level qualifies, every command output (`hs_cmd_n_flt`, `ls_cmd_n_flt`) is 1 (inactive) and `drv_en_flt` is 0.
- R2: A raw level that differs from the filtered output and is sampled on `QUAL_CYCLES` consecutive clock edges is taken by the output on the last of those edges. That is `QUAL_CYCLES-1` edges after the first edge that sampled it. The output takes no other value.
- R3: A high-going pulse on a line that idles low, lasting fewer than `QUAL_CYCLES` cycles, leaves the output unchanged.
- R4: A low-going pulse on a line that idles high, lasting fewer than `QUAL_CYCLES` cycles, leaves the output unchanged.
- R5: A pulse lasting at least `QUAL_CYCLES` cycles appears at the output with exactly the same width in cycles, with two output transitions.
- R6: A pulse of `2*QUAL_CYCLES` cycles or longer is always passed.
- R7: If the raw input returns to the filtered level before qualification completes, the count restarts from zero. Two sub-threshold pulses separated by a one-cycle return are both rejected.
- R8: All seven channels use the same filter and run independently. Channel activity on one line never changes another line's output.
- R9: After `rst_n` rises, the filters start sampling on the third rising clock edge. The first two edges are used by the reset synchroniser.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hs_cmd_n_raw | input | NUM_PH | Raw high-side commands, active low |
| ls_cmd_n_raw | input | NUM_PH | Raw low-side commands, active low |
| drv_en_raw | input | 1 | Raw enable, active high |
| hs_cmd_n_flt | output | NUM_PH | Filtered high-side commands |
| ls_cmd_n_flt | output | NUM_PH | Filtered low-side commands |
| drv_en_flt | output | 1 | Filtered enable |

## Verification
The bench drives inputs on falling edges and reads the outputs on falling edges. A level driven just before rising edge k becomes visible at the falling edge `QUAL_CYCLES` cycles after it was driven. A pulse therefore reappears shifted by that amount with its width unchanged. A bench model compares all seven outputs on every falling edge. The model uses run lengths of identical raw samples, and it skips the two synchroniser edges after each reset release. Directed cases measure output width and transition counts after the pulse has had `2*QUAL_CYCLES` cycles to settle.

// File: rtl/gif_pkg.sv
package gif_pkg;
  // Idle level of a channel: command lines (active low) idle high,
  // the enable line (last channel) idles low.
  function automatic logic chan_idle(input int unsigned idx, input int unsigned num_cmd);
    return (idx < num_cmd) ? 1'b1 : 1'b0;
  endfunction
endpackage

// File: rtl/gif_rst_sync.sv
module gif_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/gif_chan.sv
module gif_chan #(
  parameter int unsigned QUAL_CYCLES = 25,
  parameter logic        IDLE_LVL    = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic flt_o
);
  localparam int unsigned CNT_W = (QUAL_CYCLES > 2) ? $clog2(QUAL_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(QUAL_CYCLES - 1);

  logic             flt_q, flt_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             differ, at_last, upd_en;

  always_comb begin
    differ  = raw_i ^ flt_q;
    at_last = (cnt_q == LAST);
    upd_en  = differ | (cnt_q != '0);
    flt_d   = flt_q;
    cnt_d   = cnt_q;
    if (!differ) begin
      cnt_d = '0;
    end else if (at_last) begin
      flt_d = raw_i;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_q <= IDLE_LVL;
      cnt_q <= '0;
    end else if (upd_en) begin
      flt_q <= flt_d;
      cnt_q <= cnt_d;
    end
  end

  assign flt_o = flt_q;

  // R2
  flip_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(flt_o) |-> (flt_o == $past(raw_i)));
  // R7
  hold_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_i == flt_o) |=> $stable(flt_o));
  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  // R5
  flip_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(flt_o) |-> ($past(cnt_q) == LAST));
endmodule

// File: rtl/gate_in_filter.sv
module gate_in_filter #(
  parameter int unsigned NUM_PH      = 3,
  parameter int unsigned QUAL_CYCLES = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_PH-1:0] hs_cmd_n_raw,
  input  logic [NUM_PH-1:0] ls_cmd_n_raw,
  input  logic              drv_en_raw,
  output logic [NUM_PH-1:0] hs_cmd_n_flt,
  output logic [NUM_PH-1:0] ls_cmd_n_flt,
  output logic              drv_en_flt
);
  import gif_pkg::*;

  localparam int unsigned NUM_CMD = 2 * NUM_PH;
  localparam int unsigned NUM_CH  = NUM_CMD + 1;

  logic              srst_n;
  logic [NUM_CH-1:0] raw_vec, flt_vec;

  gif_rst_sync u_rst_sync (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  assign raw_vec = {drv_en_raw, ls_cmd_n_raw, hs_cmd_n_raw};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    gif_chan #(
      .QUAL_CYCLES(QUAL_CYCLES),
      .IDLE_LVL   (chan_idle(c, NUM_CMD))
    ) u_chan (
      .clk  (clk),
      .rst_n(srst_n),
      .raw_i(raw_vec[c]),
      .flt_o(flt_vec[c])
    );
  end

  assign hs_cmd_n_flt = flt_vec[NUM_PH-1:0];
  assign ls_cmd_n_flt = flt_vec[NUM_CMD-1:NUM_PH];
  assign drv_en_flt   = flt_vec[NUM_CMD];

  // R8
  chan_indep_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (raw_vec == flt_vec) |=> $stable(flt_vec));
endmodule

// File: tb/gate_in_filter_bench.sv
module gate_in_filter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NPH = 3;
  localparam int Q   = 25;
  localparam int NCH = 2 * NPH + 1;
  localparam logic [NCH-1:0] IDLE = {1'b0, {(2*NPH){1'b1}}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] raw = IDLE;
  logic [NPH-1:0] hs_f, ls_f;
  logic en_f;
  wire  [NCH-1:0] flt = {en_f, ls_f, hs_f};

  int checks = 0, fails = 0;
  bit model_on = 1'b0;

  gate_in_filter #(.NUM_PH(NPH), .QUAL_CYCLES(Q)) u_gate_in_filter (
    .clk(clk), .rst_n(rst_n),
    .hs_cmd_n_raw(raw[NPH-1:0]), .ls_cmd_n_raw(raw[2*NPH-1:NPH]),
    .drv_en_raw(raw[2*NPH]),
    .hs_cmd_n_flt(hs_f), .ls_cmd_n_flt(ls_f), .drv_en_flt(en_f));

  always #(CLK_PERIOD/2) clk = ~clk;

  // Bench model: output follows a raw level once that level has been seen
  // on Q consecutive live edges.
  logic [NCH-1:0] exp_v = IDLE, last_raw = IDLE;
  int run_len [NCH];
  int rel_cnt = 0;

  function automatic logic next_exp(logic cur, logic r, int run);
    return (run >= Q) ? r : cur;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_v = IDLE; rel_cnt = 0;
      for (int c = 0; c < NCH; c++) run_len[c] = 0;
    end else if (rel_cnt < 2) begin
      rel_cnt++;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (raw[c] == last_raw[c] && run_len[c] > 0) run_len[c] = (run_len[c] < Q) ? run_len[c] + 1 : Q;
        else run_len[c] = 1;
        exp_v[c] = next_exp(exp_v[c], raw[c], run_len[c]);
      end
      last_raw = raw;
    end
  end

  // Per-cycle comparison plus transition / width monitors.
  int toggles [NCH];
  int away    [NCH];
  logic [NCH-1:0] prev_flt = IDLE;

  always @(negedge clk) begin
    if (model_on) begin
      checks++;
      if (flt !== exp_v) begin
        fails++;
        $display("FAIL R8 cycle compare: got %b expected %b", flt, exp_v);
      end
    end
    for (int c = 0; c < NCH; c++) begin
      if (flt[c] !== prev_flt[c]) toggles[c]++;
      if (flt[c] !== IDLE[c]) away[c]++;
    end
    prev_flt = flt;
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic clr_mon();
    for (int c = 0; c < NCH; c++) begin toggles[c] = 0; away[c] = 0; end
  endtask

  // Drive a pulse away from idle on one channel, then let it settle.
  task automatic pulse(input int ch, input int width);
    clr_mon();
    @(negedge clk); raw[ch] = ~IDLE[ch];
    repeat (width) @(negedge clk);
    raw[ch] = IDLE[ch];
    repeat (2*Q + 2) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; raw = IDLE;
    #1;
    check(flt === IDLE, "R1 outputs idle in reset", int'(flt), int'(IDLE));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(flt === IDLE, "R1 outputs idle after release", int'(flt), int'(IDLE));
  endtask

  int hold [NCH];

  initial begin
    void'($urandom(32'd4021));
    for (int c = 0; c < NCH; c++) begin toggles[c] = 0; away[c] = 0; run_len[c] = 0; hold[c] = 0; end
    do_reset();
    model_on = 1'b1;

    // R9: held level just before release qualifies Q edges after the 2 sync edges
    @(negedge clk); rst_n = 1'b0; raw = IDLE; raw[0] = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    repeat (2 + Q - 1) @(negedge clk);
    check(flt[0] === 1'b1, "R9 not yet qualified", flt[0], 1);
    @(negedge clk);
    check(flt[0] === 1'b0, "R9 qualified on third-edge start", flt[0], 0);
    raw[0] = 1'b1; repeat (2*Q) @(negedge clk);

    // R3: high-going enable pulse of Q-1 rejected
    pulse(2*NPH, Q-1);
    check(toggles[2*NPH] == 0, "R3 narrow high pulse", toggles[2*NPH], 0);
    // R4: low-going command pulse of Q-1 rejected
    pulse(1, Q-1);
    check(toggles[1] == 0, "R4 narrow low pulse", toggles[1], 0);
    // R5: exactly Q passes with width Q
    pulse(NPH, Q);
    check(away[NPH] == Q, "R5 width at Q", away[NPH], Q);
    check(toggles[NPH] == 2, "R5 transitions at Q", toggles[NPH], 2);
    // R5: Q+7 keeps width
    pulse(2*NPH, Q+7);
    check(away[2*NPH] == Q+7, "R5 width at Q+7", away[2*NPH], Q+7);
    // R6: 2Q passes
    pulse(2, 2*Q);
    check(away[2] == 2*Q, "R6 width at 2Q", away[2], 2*Q);
    // R2: latency exactly Q falling edges after drive
    clr_mon();
    @(negedge clk); raw[4] = 1'b0;
    repeat (Q-1) @(negedge clk);
    check(ls_f[1] === 1'b1, "R2 before latency", ls_f[1], 1);
    @(negedge clk);
    check(ls_f[1] === 1'b0, "R2 at latency", ls_f[1], 0);
    raw[4] = 1'b1; repeat (2*Q) @(negedge clk);
    // R7: Q-1 low, 1 high, Q-1 low -> rejected
    clr_mon();
    @(negedge clk); raw[5] = 1'b0;
    repeat (Q-1) @(negedge clk); raw[5] = 1'b1;
    @(negedge clk); raw[5] = 1'b0;
    repeat (Q-1) @(negedge clk); raw[5] = 1'b1;
    repeat (2*Q) @(negedge clk);
    check(toggles[5] == 0, "R7 restart on return", toggles[5], 0);
    // R8: activity on channel 0 leaves the others untouched
    pulse(0, 3*Q);
    for (int c = 1; c < NCH; c++)
      check(toggles[c] == 0, "R8 neighbour untouched", toggles[c], 0);

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++) begin
        if (hold[c] == 0) begin
          raw[c] = 1'($urandom_range(0, 1));
          hold[c] = $urandom_range(1, 2*Q + 3);
        end else hold[c]--;
      end
      if (n == 2000) begin
        rst_n = 1'b0; #1;
        check(flt === IDLE, "R1 async reset mid-run", int'(flt), int'(IDLE));
        @(negedge clk); rst_n = 1'b1;
      end
    end
    repeat (2*Q) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule